// File: doc/BRIEF.md
# Halfword Store Address Generation Unit

This block turns a 32-bit halfword-store instruction word into a store request for a 64-bit data bus and, where the instruction asks for it, a new value for the base register. It recognises three addressing classes. Post-index stores at the unmodified base and then writes back base plus offset. Pre-index stores at base plus offset and writes back that same sum. Scaled unsigned offset stores at base plus twice a 12-bit field and writes nothing back. The two indexed classes share a signed 9-bit byte offset.

The caller supplies the base value that has already been read, either from a general register or from the stack pointer. It also supplies the 32-bit source value and a 2-bit policy. The policy decides what happens when a writeback form names the same register as both base and source. The block is one registered pipeline stage: a request presented with `in_valid` appears on the outputs one clock later, flagged by `out_valid`.

Top module: `hst_agu`

## Requirements
- R1: Every output is a register. `out_valid` equals the `in_valid` of the previous cycle, and a synchronous active-high `rst` clears every output to zero.
- R2: Post-index is recognised when word bits [31:21] are 01111000000 and bits [11:10] are 01. `st_addr` is the base, `wb_value` is the base plus the sign-extended bits [20:12], and `wb_en` is set.
- R3: Pre-index is recognised when bits [31:21] are 01111000000 and bits [11:10] are 11. `st_addr` and `wb_value` both equal the base plus the sign-extended bits [20:12], giving an offset from -256 to 255, and `wb_en` is set.
- R4: Scaled unsigned offset is recognised when bits [31:22] are 0111100100. `st_addr` is the base plus the zero-extended bits [21:10] shifted left by one (0 to 8190), and `wb_en` stays low.
- R5: The source register number is in bits [4:0] and the base register number is in bits [9:5]. The value stored is `in_src[15:0]`; bits [31:16] have no effect.
- R6: A word that matches none of the three classes sets `no_match` and leaves `st_en` and `wb_en` low.
- R7: When the base register number is 31, a base with any of its low four bits set raises `align_fault` and suppresses both store and writeback. With any other base register number, no alignment fault is raised.
- R8: When a writeback class has equal base and source numbers other than 31, policy 0 stores the original source halfword and performs the writeback.
- R9: Under the same overlap, policy 1 stores 16'hFFFF and still performs both the store and the writeback.
- R10: Under the same overlap, policy 2 raises `undef_flag` and policy 3 raises `nop_flag`; both suppress the store and the writeback. Equal register numbers in the unsigned-offset class, or base and source both 31, are not treated as overlap.
- R11: `st_strb` is the low 8 bits of 2'b11 shifted left by `st_addr[2:0]`. `st_bus` is the halfword shifted left by 8×`st_addr[2:0]` bits and truncated to 64 bits, which places the low byte in the lower lane. At lane offset 7 only lane 7 is enabled.
- R12: When `out_valid` is low, `st_en`, `wb_en` and all four flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_insn | input | 32 | Instruction word |
| in_base | input | 64 | Base value (general register or stack pointer, chosen by the caller) |
| in_src | input | 32 | Source register value |
| in_policy | input | 2 | Overlap policy: 0 keep, 1 all ones, 2 undefined, 3 no-op |
| out_valid | output | 1 | Result present this cycle |
| st_en | output | 1 | Store request |
| st_addr | output | 64 | Byte address of the store |
| st_data | output | 16 | Halfword to store |
| st_strb | output | 8 | Byte lane enables on the 64-bit bus |
| st_bus | output | 64 | Halfword placed in its lanes |
| wb_en | output | 1 | Base register writeback request |
| wb_value | output | 64 | New base register value |
| align_fault | output | 1 | Stack pointer base misaligned |
| undef_flag | output | 1 | Overlap policy raised undefined |
| nop_flag | output | 1 | Overlap policy turned the word into a no-op |
| no_match | output | 1 | Word is none of the three classes |

## Verification
The assertions assume that every input is a known value whenever `in_valid` is high. They also assume that when the base field is 31, `in_base` already carries the stack pointer, since the block cannot tell which register the caller read. The bench changes inputs only on the falling edge and always drives defined words, bases and policies. It keeps the base consistent with the register number it encodes, including aligned and misaligned stack pointer values. It also applies policy values only together with a fresh instruction word, so the policy never changes in the middle of an operation.

// File: rtl/hst_agu_pkg.sv
package hst_agu_pkg;

    localparam int unsigned HS_AW      = 64;
    localparam int unsigned HS_SRC_W   = 32;
    localparam int unsigned HS_HALF_W  = 16;
    localparam logic [4:0]  HS_SP_NUM  = 5'd31;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_POST = 2'd1,
        FORM_PRE  = 2'd2,
        FORM_UOFF = 2'd3
    } hs_form_e;

    typedef enum logic [1:0] {
        OVL_KEEP  = 2'd0,
        OVL_ONES  = 2'd1,
        OVL_UNDEF = 2'd2,
        OVL_NOP   = 2'd3
    } hs_ovl_e;

    typedef struct packed {
        hs_form_e          form;
        logic              wback;
        logic              after;
        logic [4:0]        rt;
        logic [4:0]        rn;
        logic [HS_AW-1:0]  offset;
    } hs_dec_t;

    function automatic hs_form_e hs_classify(input logic [31:0] w);
        if (w[31:22] == 10'b0111100100)
            return FORM_UOFF;
        if (w[31:21] == 11'b01111000000 && w[11:10] == 2'b01)
            return FORM_POST;
        if (w[31:21] == 11'b01111000000 && w[11:10] == 2'b11)
            return FORM_PRE;
        return FORM_NONE;
    endfunction

endpackage

// File: rtl/hst_decode.sv
module hst_decode
    import hst_agu_pkg::*;
(
    input  logic [31:0] insn,
    output hs_dec_t     dec
);

    hs_form_e form;

    always_comb begin
        form       = hs_classify(insn);
        dec.form   = form;
        dec.rt     = insn[4:0];
        dec.rn     = insn[9:5];
        dec.wback  = (form == FORM_POST) || (form == FORM_PRE);
        dec.after  = (form == FORM_POST);
        if (form == FORM_UOFF)
            dec.offset = {{(HS_AW-13){1'b0}}, insn[21:10], 1'b0};
        else
            dec.offset = {{(HS_AW-9){insn[20]}}, insn[20:12]};
    end

endmodule

// File: rtl/hst_lanes.sv
module hst_lanes #(
    parameter  int unsigned BUS_BYTES = 8,
    localparam int unsigned LW        = $clog2(BUS_BYTES)
) (
    input  logic [LW-1:0]          lane,
    input  logic [15:0]            half,
    output logic [BUS_BYTES-1:0]   strb,
    output logic [8*BUS_BYTES-1:0] bus
);

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign strb[i]       = (lane == LW'(i));
            assign bus[8*i +: 8] = (lane == LW'(i)) ? half[7:0] : 8'h00;
        end else begin : g_rest
            logic lo_here;
            logic hi_here;
            assign lo_here       = (lane == LW'(i));
            assign hi_here       = (lane == LW'(i-1));
            assign strb[i]       = lo_here | hi_here;
            assign bus[8*i +: 8] = lo_here ? half[7:0] :
                                   hi_here ? half[15:8] : 8'h00;
        end
    end

endmodule

// File: rtl/hst_agu.sv
module hst_agu
    import hst_agu_pkg::*;
#(
    parameter  int unsigned BUS_BYTES     = 8,
    parameter  int unsigned SP_ALIGN_BITS = 4,
    localparam int unsigned LW            = $clog2(BUS_BYTES),
    localparam int unsigned BUS_W         = 8 * BUS_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [31:0]           in_insn,
    input  logic [HS_AW-1:0]      in_base,
    input  logic [HS_SRC_W-1:0]   in_src,
    input  logic [1:0]            in_policy,
    output logic                  out_valid,
    output logic                  st_en,
    output logic [HS_AW-1:0]      st_addr,
    output logic [HS_HALF_W-1:0]  st_data,
    output logic [BUS_BYTES-1:0]  st_strb,
    output logic [BUS_W-1:0]      st_bus,
    output logic                  wb_en,
    output logic [HS_AW-1:0]      wb_value,
    output logic                  align_fault,
    output logic                  undef_flag,
    output logic                  nop_flag,
    output logic                  no_match
);

    hs_dec_t                dec;
    hs_ovl_e                pol;
    logic [HS_AW-1:0]       sum;
    logic [HS_AW-1:0]       acc_addr;
    logic [HS_HALF_W-1:0]   half;
    logic [BUS_BYTES-1:0]   strb_c;
    logic [BUS_W-1:0]       bus_c;
    logic                   match, overlap, sp_bad, c_undef, c_nop, go;
    wire                    unused_src_hi = ^in_src[HS_SRC_W-1:HS_HALF_W];

    hst_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    always_comb begin
        pol      = hs_ovl_e'(in_policy);
        sum      = in_base + dec.offset;
        acc_addr = dec.after ? in_base : sum;
        match    = (dec.form != FORM_NONE);
        overlap  = dec.wback && (dec.rn == dec.rt) && (dec.rn != HS_SP_NUM);
        c_undef  = match && overlap && (pol == OVL_UNDEF);
        c_nop    = match && overlap && (pol == OVL_NOP);
        sp_bad   = match && (dec.rn == HS_SP_NUM) && (|in_base[SP_ALIGN_BITS-1:0]);
        go       = match && !c_undef && !c_nop && !sp_bad;
        half     = (overlap && pol == OVL_ONES) ? '1 : in_src[HS_HALF_W-1:0];
    end

    hst_lanes #(.BUS_BYTES(BUS_BYTES)) u_lanes (
        .lane (acc_addr[LW-1:0]),
        .half (half),
        .strb (strb_c),
        .bus  (bus_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            st_en       <= 1'b0;
            wb_en       <= 1'b0;
            align_fault <= 1'b0;
            undef_flag  <= 1'b0;
            nop_flag    <= 1'b0;
            no_match    <= 1'b0;
            st_addr     <= '0;
            st_data     <= '0;
            st_strb     <= '0;
            st_bus      <= '0;
            wb_value    <= '0;
        end else begin
            out_valid   <= in_valid;
            st_en       <= in_valid && go;
            wb_en       <= in_valid && go && dec.wback;
            align_fault <= in_valid && sp_bad;
            undef_flag  <= in_valid && c_undef;
            nop_flag    <= in_valid && c_nop;
            no_match    <= in_valid && !match;
            st_addr     <= acc_addr;
            st_data     <= half;
            st_strb     <= strb_c;
            st_bus      <= bus_c;
            wb_value    <= sum;
        end
    end

endmodule

// File: rtl/hst_agu_chk.sv
module hst_agu_chk
    import hst_agu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       in_insn,
    input logic [HS_AW-1:0]  in_base,
    input logic              out_valid,
    input logic              st_en,
    input logic              wb_en,
    input logic [HS_AW-1:0]  st_addr,
    input logic [HS_AW-1:0]  wb_value,
    input logic [7:0]        st_strb,
    input logic              align_fault,
    input logic              undef_flag,
    input logic              nop_flag,
    input logic              no_match
);

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_post_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hs_classify(in_insn) == FORM_POST) |=> (!st_en || st_addr == $past(in_base)));

    p_wb_needs_store_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> st_en);

    p_pre_same_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hs_classify(in_insn) == FORM_PRE) |=> (!wb_en || wb_value == st_addr));

    p_uoff_nowb_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hs_classify(in_insn) == FORM_UOFF) |=> !wb_en);

    p_nomatch_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hs_classify(in_insn) == FORM_NONE) |=> (no_match && !st_en));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_en, align_fault, undef_flag, nop_flag, no_match}));

    p_strb_count_r11: assert property (@(posedge clk) disable iff (rst)
        st_en |-> ($countones(st_strb) == 1 || $countones(st_strb) == 2));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(st_en || wb_en || align_fault || undef_flag || nop_flag || no_match));

endmodule

bind hst_agu hst_agu_chk u_chk (.*);

// File: tb/hst_agu_test.sv
`timescale 1ns/1ps
module hst_agu_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_insn;
    logic [63:0] in_base;
    logic [31:0] in_src;
    logic [1:0]  in_policy;
    logic        out_valid, st_en, wb_en, align_fault, undef_flag, nop_flag, no_match;
    logic [63:0] st_addr, wb_value, st_bus;
    logic [15:0] st_data;
    logic [7:0]  st_strb;

    always #2 clk = ~clk;

    hst_agu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_base(in_base), .in_src(in_src), .in_policy(in_policy),
        .out_valid(out_valid), .st_en(st_en), .st_addr(st_addr),
        .st_data(st_data), .st_strb(st_strb), .st_bus(st_bus),
        .wb_en(wb_en), .wb_value(wb_value), .align_fault(align_fault),
        .undef_flag(undef_flag), .nop_flag(nop_flag), .no_match(no_match)
    );

    typedef struct {
        logic [5:0]  flags;
        logic [63:0] addr;
        logic [63:0] wbv;
        logic [15:0] data;
        logic [7:0]  strb;
        logic [63:0] bus;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    bit   mon_on = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] w_post(input logic [8:0] imm, input logic [4:0] rn, input logic [4:0] rt);
        return {11'h3C0, imm, 2'b01, rn, rt};
    endfunction
    function automatic logic [31:0] w_pre(input logic [8:0] imm, input logic [4:0] rn, input logic [4:0] rt);
        return {11'h3C0, imm, 2'b11, rn, rt};
    endfunction
    function automatic logic [31:0] w_uoff(input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt);
        return {10'h1E4, imm, rn, rt};
    endfunction

    // flags order: st_en, wb_en, align_fault, undef_flag, nop_flag, no_match
    function automatic exp_t model(input logic [31:0] w, input logic [63:0] b,
                                   input logic [31:0] s, input logic [1:0] p, input string tag);
        exp_t        e;
        bit          is_post, is_pre, is_uoff, wb, ovl, bad_sp, ok;
        logic [63:0] off;
        is_uoff = (w[31:22] == 10'h1E4);
        is_post = (w[31:21] == 11'h3C0) && (w[11:10] == 2'b01);
        is_pre  = (w[31:21] == 11'h3C0) && (w[11:10] == 2'b11);
        wb      = is_post || is_pre;
        off     = is_uoff ? {51'b0, w[21:10], 1'b0} : {{55{w[20]}}, w[20:12]};
        ovl     = wb && (w[9:5] == w[4:0]) && (w[9:5] != 5'd31);
        bad_sp  = (w[9:5] == 5'd31) && (b[3:0] != 4'h0);
        e.tag   = tag;
        e.addr  = is_post ? b : b + off;
        e.wbv   = b + off;
        e.data  = (ovl && p == 2'd1) ? 16'hFFFF : s[15:0];
        e.strb  = 8'(16'h3 << e.addr[2:0]);
        e.bus   = {48'b0, e.data} << (8 * e.addr[2:0]);
        if (!(is_post || is_pre || is_uoff)) begin
            e.flags = 6'b000001;
        end else if (ovl && p == 2'd2) begin
            e.flags = 6'b000100;
        end else if (ovl && p == 2'd3) begin
            e.flags = 6'b000010;
        end else if (bad_sp) begin
            e.flags = 6'b001000;
        end else begin
            ok      = 1'b1;
            e.flags = {ok, wb, 4'b0000};
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] w, input logic [63:0] b, input logic [31:0] s,
                        input logic [1:0] p, input string tag);
        @(negedge clk);
        in_insn   = w;
        in_base   = b;
        in_src    = s;
        in_policy = p;
        in_valid  = 1'b1;
        q.push_back(model(w, b, s, p, tag));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_insn  = 32'h0;
        end
    endtask

    // monitor: compares each produced result with the oldest expected item
    always @(negedge clk) begin : monitor
        exp_t e;
        if (mon_on && !rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check("R1", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    check(e.tag, "flags", {58'b0, st_en, wb_en, align_fault, undef_flag, nop_flag, no_match},
                          {58'b0, e.flags});
                    if (e.flags[5]) begin
                        check(e.tag, "st_addr", st_addr, e.addr);
                        check(e.tag, "st_data R5", {48'b0, st_data}, {48'b0, e.data});
                        check(e.tag, "st_strb R11", {56'b0, st_strb}, {56'b0, e.strb});
                        check(e.tag, "st_bus R11", st_bus, e.bus);
                    end
                    if (e.flags[4])
                        check(e.tag, "wb_value", wb_value, e.wbv);
                end
            end else begin
                check("R12", "idle enables/flags",
                      {58'b0, st_en, wb_en, align_fault, undef_flag, nop_flag, no_match}, 64'd0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin : driver
        rst       = 1'b1;
        in_valid  = 1'b1;
        in_insn   = w_post(9'h010, 5'd2, 5'd3);
        in_base   = 64'h40;
        in_src    = 32'h1234_5678;
        in_policy = 2'd0;
        repeat (3) @(negedge clk);
        check("R1", "reset ctrl", {57'b0, out_valid, st_en, wb_en, align_fault, undef_flag, nop_flag, no_match}, 64'd0);
        check("R1", "reset st_addr", st_addr, 64'd0);
        check("R1", "reset wb_value", wb_value, 64'd0);
        check("R1", "reset data", {st_bus[47:0], st_data}, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        mon_on   = 1'b1;
        idle(2);

        send(w_post(9'h1F0, 5'd3, 5'd4), 64'h1000_0000_0000_0040, 32'hABCD_1234, 2'd0, "R2");
        send(w_pre(9'h0FF, 5'd3, 5'd4), 64'h100, 32'h5555_BEEF, 2'd0, "R3");
        send(w_pre(9'h100, 5'd3, 5'd4), 64'h1000, 32'h0000_7777, 2'd0, "R3");
        idle(1);
        send(w_uoff(12'hFFF, 5'd5, 5'd5), 64'h2000, 32'h0000_C0DE, 2'd2, "R10");
        send(w_uoff(12'h000, 5'd6, 5'd1), 64'h3, 32'h0000_A55A, 2'd0, "R4");
        send(w_uoff(12'h001, 5'd6, 5'd1), 64'h1, 32'h0000_1122, 2'd0, "R11");
        send(w_uoff(12'h010, 5'd2, 5'd8), 64'h40, 32'hFFFF_0001, 2'd0, "R5");
        send(32'h7800_0000, 64'h80, 32'h1, 2'd0, "R6");
        send(32'h0000_0000, 64'h80, 32'h1, 2'd0, "R6");
        send(32'h7800_0800, 64'h80, 32'h1, 2'd0, "R6");
        idle(2);
        send(w_pre(9'h004, 5'd31, 5'd2), 64'h8000_0008, 32'h0000_4444, 2'd0, "R7");
        send(w_uoff(12'h002, 5'd31, 5'd2), 64'h8000_0001, 32'h0000_4444, 2'd0, "R7");
        send(w_pre(9'h004, 5'd9, 5'd2), 64'h8000_0008, 32'h0000_4444, 2'd0, "R7");
        send(w_post(9'h010, 5'd31, 5'd31), 64'h8000_0010, 32'h0000_9999, 2'd2, "R10");
        send(w_post(9'h002, 5'd7, 5'd7), 64'h4000, 32'h0000_3C3C, 2'd0, "R8");
        send(w_post(9'h002, 5'd7, 5'd7), 64'h4000, 32'h0000_3C3C, 2'd1, "R9");
        send(w_pre(9'h1FE, 5'd7, 5'd7), 64'h4005, 32'h0000_3C3C, 2'd1, "R9");
        send(w_post(9'h002, 5'd7, 5'd7), 64'h4000, 32'h0000_3C3C, 2'd2, "R10");
        send(w_pre(9'h002, 5'd7, 5'd7), 64'h4000, 32'h0000_3C3C, 2'd3, "R10");
        idle(1);
        for (int i = 0; i < 48; i++) begin
            logic [63:0] b;
            b = 64'h0000_1000_0000_0000 + 64'(i * 37);
            case (i % 3)
                0: send(w_post(9'(i * 29), 5'(i % 31), 5'((i + 1) % 31)), b, 32'(i * 32'h01010101), 2'(i), "R2");
                1: send(w_pre(9'(i * 53), 5'(i % 31), 5'((i + 3) % 31)), b, 32'(i * 32'h00370011), 2'(i), "R3");
                default: send(w_uoff(12'(i * 91), 5'(i % 31), 5'(i % 31)), b, 32'(i * 32'h00010203), 2'(i), "R4");
            endcase
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        check("R1", "results outstanding", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule